// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects six interrupt sources for a small 8-bit processor core, latches each event into a request register, and filters the pending set through per-source enables and one global enable. Among the enabled pending sources, a configurable priority ordering picks one winner. The block then raises a grant that carries the winner's index and its vector address, which is the location of a two-byte service-routine pointer.

Taking a grant clears the global enable on its own. No later grant is issued until software sets that enable again. The grant stays up, unchanged, until the core acknowledges it. The acknowledge clears the served request bit.

Polled operation uses the same register set. With the global enable left at zero, events still accumulate in the request register and software can read it. Three sources are external pins passed through a synchronizer. For two of those pins, software chooses the active edge through a two-bit field in the request register. The remaining sources are two timer event pulses and one signal-processor event pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the request register (including its edge field), the enable register and the priority register all read zero, and `grant_valid` is low.
- R2: Source mapping: pin 0 sets request bit 0, pin 1 sets bit 1 on a falling edge only, pin 2 sets bit 2, `dsp_evt` sets bit 3, `tmr_evt[0]` sets bit 4 and `tmr_evt[1]` sets bit 5. Pin changes are synchronized over two flops before edge detection.
- R3: The request register bits 7:6 (`esel`) choose the edges for pins 0 and 2. Pin 0 detects rising edges when `esel` is 01 or 11, and falling edges when `esel` is 00, 10 or 11. Pin 2 detects rising edges when `esel` is 10 or 11, and falling edges when `esel` is 00, 01 or 11.
- R4: Software writes the request register (`wr_sel`=0) with `{esel, req[5:0]}`. If an event and a software clear of the same bit happen in one cycle, the bit ends up set.
- R5: While the global enable is 0, no grant is raised, and events keep setting request bits.
- R6: A grant is taken only when the global enable is 1, no grant is outstanding, and at least one request bit is set whose enable bit is set. The enable register (`wr_sel`=1) holds the global enable in bit 7 and the per-source enables in bits 5:0.
- R7: The priority register (`wr_sel`=2) groups the sources as G0={0,1}, G1={2,3} and G2={4,5}. Bits 2:0 give the group order from highest to lowest: 0 gives G0,G1,G2; 1 gives G0,G2,G1; 2 gives G1,G0,G2; 3 gives G1,G2,G0; 4 gives G2,G0,G1; 5 gives G2,G1,G0; 6 and 7 give G0,G1,G2. Within group g, the lower index wins unless bit 3+g is set, in which case the higher index wins.
- R8: Taking a grant clears the global enable in the same clock, and the clear takes precedence over a software write in that cycle.
- R9: While `grant_valid` is high and `grant_ack` is low, `grant_src` stays stable and no other grant replaces it. `grant_vec` equals VEC_BASE + 2*`grant_src`.
- R10: A `grant_ack` during a grant drops `grant_valid` and clears the granted request bit, unless a new event for that source arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| tmr_evt | input | 2 | Timer event pulses, one cycle each |
| dsp_evt | input | 1 | Signal-processor event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 request, 1 enable, 2 priority |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select, same coding as wr_sel |
| rd_data | output | 8 | Combinational read data |
| grant_valid | output | 1 | Grant outstanding |
| grant_src | output | 3 | Index of the granted source |
| grant_vec | output | 16 | Vector address of the granted source |
| grant_ack | input | 1 | Core acknowledge of the grant |

## Verification
The assertions assume that `grant_ack` is only pulsed while a grant is outstanding, and that timer and signal-processor events are single-cycle pulses synchronous to `clk`. They also assume that the external pins hold each level for at least two clocks. The bench drives every input on the falling clock edge and pulses the acknowledge only after it has seen `grant_valid`. It holds each pin level for several cycles before it reads the request register. The random priority trials load requests by software write while the global enable is 0, so no grant can start partway through setup.

// File: rtl/irq_pkg.sv
// Package: shared constants, types and the group-order table for the
// interrupt controller. Assumes exactly three groups of two sources.
package irq_pkg;
    localparam int NSRC  = 6;
    localparam int IDXW  = 3;
    localparam int NGRP  = 3;

    localparam logic [1:0] REG_REQ = 2'd0;
    localparam logic [1:0] REG_ENA = 2'd1;
    localparam logic [1:0] REG_PRI = 2'd2;

    typedef logic [IDXW-1:0] src_idx_t;

    // Group order, first group in the top two bits.
    function automatic logic [5:0] grp_order(input logic [2:0] sel);
        case (sel)
            3'd1:    return {2'd0, 2'd2, 2'd1};
            3'd2:    return {2'd1, 2'd0, 2'd2};
            3'd3:    return {2'd1, 2'd2, 2'd0};
            3'd4:    return {2'd2, 2'd0, 2'd1};
            3'd5:    return {2'd2, 2'd1, 2'd0};
            default: return {2'd0, 2'd1, 2'd2};
        endcase
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
// Module: synchronizes one asynchronous pin and flags selected edges.
// Assumes the pin holds each level for at least STAGES clocks.
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_en,
    input  logic fall_en,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer flops.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Keep the last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    // Report an edge of an enabled kind.
    always_comb begin
        evt = (rise_en &&  chain[STAGES-1] && !prev) ||
              (fall_en && !chain[STAGES-1] &&  prev);
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: picks the highest-ranked pending source from the group order
// and the per-group swap bits. Purely combinational.
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [5:0]      prio_cfg,
    output logic            any_o,
    output src_idx_t        win_o
);
    logic [5:0] ord;

    // Walk groups in rank order, two members each, first hit wins.
    always_comb begin
        ord   = grp_order(prio_cfg[2:0]);
        any_o = 1'b0;
        win_o = '0;
        for (int pos = 0; pos < NGRP; pos++) begin
            logic [1:0] g;
            logic       sw;
            g  = ord[5-2*pos -: 2];
            sw = (g == 2'd0) ? prio_cfg[3] : (g == 2'd1) ? prio_cfg[4] : prio_cfg[5];
            for (int k = 0; k < 2; k++) begin
                logic [2:0] idx;
                idx = {g, sw ^ k[0]};
                if (!any_o && pend[idx]) begin
                    any_o = 1'b1;
                    win_o = idx;
                end
            end
        end
    end

    // The reported winner must be among the pending sources.
    always_comb begin
        if (any_o) begin
            p_win_pending_r7: assert (pend[win_o]);
        end
        p_none_when_idle_r6: assert (any_o == (pend != '0));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: six-source interrupt controller top. Latches events, masks,
// prioritizes, grants with a vector and waits for the core's acknowledge.
// Assumes grant_ack is pulsed only while grant_valid is high.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          VEC_W       = 16,
    parameter logic [15:0] VEC_BASE    = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ext_pin,
    input  logic [1:0]       tmr_evt,
    input  logic             dsp_evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_sel,
    output logic [7:0]       rd_data,
    output logic             grant_valid,
    output logic [IDXW-1:0]  grant_src,
    output logic [VEC_W-1:0] grant_vec,
    input  logic             grant_ack
);
    localparam int NPIN = 3;

    logic [NSRC-1:0] req_q, ena_q;
    logic [1:0]      esel_q;
    logic            ge_q;
    logic [5:0]      prio_q;
    logic [NPIN-1:0] rise_en, fall_en, pin_evt;
    logic [NSRC-1:0] set_evt, pend;
    logic            any_win, take;
    src_idx_t        win;

    // Edge enables per pin from the edge-select field.
    always_comb begin
        rise_en = {esel_q[1], 1'b0, esel_q[0]};
        fall_en = {esel_q != 2'b10, 1'b1, esel_q != 2'b01};
    end

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .pin(ext_pin[p]),
                .rise_en(rise_en[p]), .fall_en(fall_en[p]), .evt(pin_evt[p])
            );
        end
    endgenerate

    // Collect event pulses in request-bit order.
    always_comb begin
        set_evt = {tmr_evt[1], tmr_evt[0], dsp_evt, pin_evt};
        pend    = req_q & ena_q;
    end

    irq_prio_pick u_pick (
        .pend(pend), .prio_cfg(prio_q), .any_o(any_win), .win_o(win)
    );

    // Decide whether a grant is taken this cycle.
    always_comb begin
        take = ge_q && !grant_valid && any_win;
    end

    // Request register: software write, acknowledge clear, then events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            esel_q <= '0;
        end else begin
            logic [NSRC-1:0] nxt;
            nxt = req_q;
            if (wr_en && wr_sel == REG_REQ) begin
                nxt    = wr_data[NSRC-1:0];
                esel_q <= wr_data[7:6];
            end
            if (grant_valid && grant_ack) nxt[grant_src] = 1'b0;
            req_q <= nxt | set_evt;
        end
    end

    // Enable and priority registers; a taken grant clears the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q  <= '0;
            ge_q   <= 1'b0;
            prio_q <= '0;
        end else begin
            if (wr_en && wr_sel == REG_ENA) begin
                ena_q <= wr_data[NSRC-1:0];
                ge_q  <= wr_data[7];
            end
            if (wr_en && wr_sel == REG_PRI) prio_q <= wr_data[5:0];
            if (take) ge_q <= 1'b0;
        end
    end

    // Grant holder: set on take, held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_src   <= '0;
        end else if (take) begin
            grant_valid <= 1'b1;
            grant_src   <= win;
        end else if (grant_valid && grant_ack) begin
            grant_valid <= 1'b0;
        end
    end

    // Vector address and register read-back.
    always_comb begin
        grant_vec = VEC_BASE + VEC_W'({grant_src, 1'b0});
        case (rd_sel)
            REG_REQ: rd_data = {esel_q, req_q};
            REG_ENA: rd_data = {ge_q, 1'b0, ena_q};
            REG_PRI: rd_data = {2'b00, prio_q};
            default: rd_data = 8'h00;
        endcase
    end

    p_grant_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((($past(pend) >> grant_src) & 6'd1) != 0) && $past(ge_q));

    p_take_clears_ge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> !ge_q);

    p_grant_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_ack |=> grant_valid && $stable(grant_src));

    p_polled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ge_q && !grant_valid |=> !grant_valid);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_ack && !(wr_en && wr_sel == REG_REQ) && !set_evt[grant_src]
        |=> !grant_valid && !req_q[$past(grant_src)]);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [1:0] tmr_evt = '0;
    logic       dsp_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       grant_valid;
    logic [2:0] grant_src;
    logic [15:0] grant_vec;
    logic       grant_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
        .dsp_evt(dsp_evt), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .grant_valid(grant_valid),
        .grant_src(grant_src), .grant_vec(grant_vec), .grant_ack(grant_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        rd_sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Which request bits 0..2 a pin transition should set, from the edge table.
    function automatic logic [2:0] exp_pin_bits(input logic [1:0] es, input bit rising);
        logic [2:0] r;
        r[1] = !rising;
        if (rising) begin
            r[0] = (es == 2'b01) || (es == 2'b11);
            r[2] = (es == 2'b10) || (es == 2'b11);
        end else begin
            r[0] = (es == 2'b00) || (es == 2'b10) || (es == 2'b11);
            r[2] = (es == 2'b00) || (es == 2'b01) || (es == 2'b11);
        end
        return r;
    endfunction

    // Rank-based winner model; returns -1 when nothing is pending.
    function automatic int exp_win(input logic [5:0] pend, input logic [5:0] pr);
        int gorder [8][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0},
                              '{2,0,1}, '{2,1,0}, '{0,1,2}, '{0,1,2}};
        int best = -1;
        int best_rank = 99;
        for (int s = 0; s < 6; s++) begin
            int g = s / 2;
            int gp = 0;
            int rank;
            for (int p = 0; p < 3; p++) if (gorder[pr[2:0]][p] == g) gp = p;
            rank = gp * 2 + ((s % 2) ^ int'(pr[3+g]));
            if (pend[s] && rank < best_rank) begin
                best = s; best_rank = rank;
            end
        end
        return best;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int seed;
        seed = $urandom(32'd2024);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, d); check("R1 req", d, 0);
        rd(2'd1, d); check("R1 ena", d, 0);
        rd(2'd2, d); check("R1 pri", d, 0);
        check("R1 grant", grant_valid, 0);

        // R3 R2 edge selection on all four field values
        for (int es = 0; es < 4; es++) begin
            wr(2'd0, {es[1:0], 6'b0});
            @(negedge clk); ext_pin = 3'b111;
            idle(6);
            rd(2'd0, d);
            check($sformatf("R3 rise esel=%0d", es), d[2:0], exp_pin_bits(es[1:0], 1'b1));
            wr(2'd0, {es[1:0], 6'b0});
            @(negedge clk); ext_pin = 3'b000;
            idle(6);
            rd(2'd0, d);
            check($sformatf("R3 fall esel=%0d", es), d[2:0], exp_pin_bits(es[1:0], 1'b0));
        end

        // R2 R5 polled: internal pulses latch, no grant while enable is off
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h3F);
        @(negedge clk); dsp_evt = 1'b1; tmr_evt = 2'b10;
        @(negedge clk); dsp_evt = 1'b0; tmr_evt = 2'b00;
        idle(3);
        rd(2'd0, d); check("R2 internal events", d[5:0], 6'h28);
        check("R5 no grant polled", grant_valid, 0);

        // R4 event beats software clear in the same cycle
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00; tmr_evt = 2'b01;
        @(negedge clk); wr_en = 1'b0; tmr_evt = 2'b00;
        rd(2'd0, d); check("R4 set wins", d[5:0], 6'h10);

        // R6 R7 R8 R9 R10 random priority trials
        for (int t = 0; t < 60; t++) begin
            logic [5:0] rq, en, pr;
            int w;
            rq = 6'($urandom); en = 6'($urandom); pr = 6'($urandom);
            wr(2'd1, 8'h00);
            wr(2'd2, {2'b00, pr});
            wr(2'd0, {2'b00, rq});
            wr(2'd1, {2'b10, en});
            idle(2);
            w = exp_win(rq & en, pr);
            if (w < 0) begin
                check("R6 no grant when nothing enabled", grant_valid, 0);
            end else begin
                check("R6 grant taken", grant_valid, 1);
                check("R7 winner", grant_src, w);
                check("R9 vector", grant_vec, 2 * w);
                rd(2'd1, d); check("R8 global enable cleared", d[7], 0);
                @(negedge clk); grant_ack = 1'b1;
                @(negedge clk); grant_ack = 1'b0;
                check("R10 grant dropped", grant_valid, 0);
                rd(2'd0, d); check("R10 bit cleared", d[5:0], rq & ~(6'd1 << w));
            end
        end

        // R9 hold while unacknowledged, even with enable re-armed
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h8A);
        idle(2);
        check("R9 first grant", grant_src, 1);
        wr(2'd1, 8'h8A);
        idle(4);
        check("R9 held", grant_valid, 1);
        check("R9 src stable", grant_src, 1);
        @(negedge clk); grant_ack = 1'b1;
        @(negedge clk); grant_ack = 1'b0;
        idle(2);
        check("R10 next grant after ack", grant_src, 3);
        check("R9 next vector", grant_vec, 6);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule